// File: doc/BRIEF.md
# Display Controller Command Decoder and Host RAM Access

This block sits between a host bus front end and the display data RAM of a dot-matrix LCD controller. The front end turns bus cycles into single-cycle pulses (command write, data write, data read, status read) that carry one byte. The block decodes command bytes into a set of mode registers: display enable, scan start line, page, column, segment direction, static drive, duty and read-modify-write. It also forms the RAM address for host accesses from the page and the column.

Host reads are pipelined through a one-entry output latch. A data read returns what the latch already holds, and then refills the latch from RAM at the current address. After any address change, the first read therefore returns stale data and serves as a dummy read. The column counter moves forward on every host data access and stops at the column count. In read-modify-write mode, reads leave the column where it is. The closing command restores the column that was saved when the mode was entered.

Top module: `lcdc_cmd_core`

## Requirements
- R1: After hardware reset the display is off, the start line is 0, the page is 3 (NUM_PAGES-1), the column is 0, static drive is off, 1/32 duty is selected (duty32_o=1), segment mapping is normal (seg_rev_o=0), read-modify-write is off and the output latch holds 0x00.
- R2: Command 0xAF sets disp_on_o and command 0xAE clears it.
- R3: Commands 0xC0 to 0xDF load start_line_o from byte bits 4:0.
- R4: Commands 0xB8 to 0xBB load the page from bits 1:0. The page sits in ram_addr_o[8:7] and never changes except through a command or a reset.
- R5: Commands 0x00 to 0x4F load the column, which sits in ram_addr_o[6:0]. Bytes 0x50 to 0x7F are ignored.
- R6: 0xA0/0xA1 clear/set seg_rev_o, 0xA4/0xA5 clear/set static_o, and 0xA8/0xA9 clear/set duty32_o (1 means 1/32 duty).
- R7: A data write drives ram_we_o with ram_wdata_o=din_i at ram_addr_o, then adds one to the column. At column 80 (0x50) the column stays put and neither ram_we_o nor ram_re_o is raised.
- R8: During a data read, host_dout_o shows the latch contents. The latch then loads the RAM byte at the current address (0x00 when the column is 80) and the column steps forward, so the first read after an address change returns stale data.
- R9: Command 0xE0 saves the column and sets rmw_o. While rmw_o is set, reads leave the column unchanged, writes still step it, and column-set commands are ignored. Command 0xEE clears rmw_o and restores the saved column. Outside the mode, 0xEE changes nothing.
- R10: During a status read, host_dout_o is {busy, ~seg_rev_o, ~disp_on_o, resetting, 4'b0000}. The busy and resetting bits are equal.
- R11: Command 0xE2 clears the start line and sets the page to 3. The display enable, the column, the other modes and the RAM are left as they were.
- R12: For RST_CYCLES (4) cycles after a hardware reset, or after an accepted 0xE2, the block is busy. While busy, command writes, data writes and data reads are ignored, and status reads still work.
- R13: Any command byte outside the listed codes changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cmd_wr_i | input | 1 | Command write pulse |
| dat_wr_i | input | 1 | Display data write pulse |
| dat_rd_i | input | 1 | Display data read pulse |
| sts_rd_i | input | 1 | Status read pulse |
| din_i | input | 8 | Command or write data byte |
| ram_rdata_i | input | 8 | RAM read data, valid in the same cycle as ram_addr_o |
| ram_addr_o | output | 9 | RAM address {page, column} |
| ram_we_o | output | 1 | RAM write enable |
| ram_re_o | output | 1 | RAM read strobe |
| ram_wdata_o | output | 8 | RAM write data |
| host_dout_o | output | 8 | Byte returned to the host (status or latch) |
| disp_on_o | output | 1 | Display enabled |
| start_line_o | output | 5 | Scan start line |
| seg_rev_o | output | 1 | Reversed segment mapping |
| static_o | output | 1 | Static drive enabled |
| duty32_o | output | 1 | 1/32 duty selected (0: 1/16) |
| rmw_o | output | 1 | Read-modify-write mode active |

## Verification
The bound checker watches several rules on every cycle. The column never exceeds 80 and no write reaches RAM at that column. The page moves only on a command. A busy command write leaves the display enable and page untouched. Reads in read-modify-write mode hold the column, each accepted write steps it by one, and the low nibble of the status is zero. The directed scenarios cover what needs a sequence of operations: the stale first read after an address change, the column being restored by the closing command, the exact length of the busy window after a soft reset, and the undefined codes leaving every register as it was.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

   localparam int BYTE_W = 8;
   localparam int LINE_W = 5;

   localparam logic [7:0] CODE_RMW_ENTER = 8'hE0;
   localparam logic [7:0] CODE_RMW_LEAVE = 8'hEE;
   localparam logic [7:0] CODE_SOFT_RST  = 8'hE2;

   typedef enum logic [3:0] {
      OP_NONE,
      OP_DISP,
      OP_START,
      OP_PAGE,
      OP_COL,
      OP_ADC,
      OP_STATIC,
      OP_DUTY,
      OP_RMW,
      OP_END,
      OP_SRST
   } op_e;

endpackage

// File: rtl/lcdc_cmd_decode.sv
module lcdc_cmd_decode
   import lcdc_pkg::*;
#(
   parameter int NUM_COLS  = 80,
   parameter int NUM_PAGES = 4
) (
   input  logic [BYTE_W-1:0] code_i,
   output op_e               op_o
);

   always_comb begin
      op_o = OP_NONE;
      if (code_i[7] == 1'b0) begin
         if (int'(code_i[6:0]) < NUM_COLS) op_o = OP_COL;
      end else if (code_i[7:5] == 3'b110) begin
         op_o = OP_START;
      end else if (code_i[7:2] == 6'b101110) begin
         if (int'(code_i[1:0]) < NUM_PAGES) op_o = OP_PAGE;
      end else if (code_i == CODE_RMW_ENTER) begin
         op_o = OP_RMW;
      end else if (code_i == CODE_RMW_LEAVE) begin
         op_o = OP_END;
      end else if (code_i == CODE_SOFT_RST) begin
         op_o = OP_SRST;
      end else begin
         case (code_i[7:1])
            7'h57:   op_o = OP_DISP;
            7'h50:   op_o = OP_ADC;
            7'h52:   op_o = OP_STATIC;
            7'h54:   op_o = OP_DUTY;
            default: op_o = OP_NONE;
         endcase
      end
   end

endmodule

// File: rtl/lcdc_col_ctr.sv
module lcdc_col_ctr #(
   parameter int NUM_COLS = 80,
   parameter int COL_W    = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [COL_W-1:0] load_val_i,
   input  logic             step_i,
   input  logic             step_is_rd_i,
   input  logic             rmw_enter_i,
   input  logic             rmw_leave_i,
   output logic [COL_W-1:0] col_o,
   output logic             rmw_o,
   output logic             at_end_o
);

   localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS);

   logic [COL_W-1:0] col_q;
   logic [COL_W-1:0] saved_q;
   logic             rmw_q;
   logic             hold_rd;

   assign at_end_o = (col_q == COL_LAST);
   assign hold_rd  = rmw_q & step_is_rd_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q   <= '0;
         saved_q <= '0;
         rmw_q   <= 1'b0;
      end else begin
         if (rmw_leave_i && rmw_q) begin
            col_q <= saved_q;
            rmw_q <= 1'b0;
         end else if (rmw_enter_i && !rmw_q) begin
            saved_q <= col_q;
            rmw_q   <= 1'b1;
         end else if (load_i && !rmw_q) begin
            col_q <= load_val_i;
         end else if (step_i && !at_end_o && !hold_rd) begin
            col_q <= col_q + COL_W'(1);
         end
      end
   end

   assign col_o = col_q;
   assign rmw_o = rmw_q;

endmodule

// File: rtl/lcdc_rd_pipe.sv
module lcdc_rd_pipe #(
   parameter int DATA_W        = 8,
   parameter bit HOLD_PAST_END = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  logic              in_range_i,
   input  logic [DATA_W-1:0] ram_data_i,
   output logic [DATA_W-1:0] latch_o
);

   logic [DATA_W-1:0] latch_q;
   logic [DATA_W-1:0] fill;

   generate
      if (HOLD_PAST_END) begin : g_hold
         assign fill = latch_q;
      end else begin : g_zero
         assign fill = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    latch_q <= '0;
      else if (rd_i) latch_q <= in_range_i ? ram_data_i : fill;
   end

   assign latch_o = latch_q;

endmodule

// File: rtl/lcdc_cmd_core.sv
module lcdc_cmd_core
   import lcdc_pkg::*;
#(
   parameter int NUM_COLS   = 80,
   parameter int NUM_PAGES  = 4,
   parameter int RST_CYCLES = 4,
   localparam int COL_W     = $clog2(NUM_COLS + 1),
   localparam int PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
   localparam int ADDR_W    = PAGE_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr_i,
   input  logic              dat_wr_i,
   input  logic              dat_rd_i,
   input  logic              sts_rd_i,
   input  logic [BYTE_W-1:0] din_i,
   input  logic [BYTE_W-1:0] ram_rdata_i,
   output logic [ADDR_W-1:0] ram_addr_o,
   output logic              ram_we_o,
   output logic              ram_re_o,
   output logic [BYTE_W-1:0] ram_wdata_o,
   output logic [BYTE_W-1:0] host_dout_o,
   output logic              disp_on_o,
   output logic [LINE_W-1:0] start_line_o,
   output logic              seg_rev_o,
   output logic              static_o,
   output logic              duty32_o,
   output logic              rmw_o
);

   localparam int               CNT_W     = $clog2(RST_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD  = CNT_W'(RST_CYCLES);
   localparam logic [PAGE_W-1:0] PAGE_TOP = PAGE_W'(NUM_PAGES - 1);

   generate
      if (NUM_COLS < 1 || NUM_COLS > 127) begin : g_bad_cols
         $error("NUM_COLS must lie in 1..127");
      end
      if (NUM_PAGES < 1 || NUM_PAGES > 4) begin : g_bad_pages
         $error("NUM_PAGES must lie in 1..4");
      end
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("RST_CYCLES must be at least 1");
      end
   endgenerate

   op_e               op;
   logic [CNT_W-1:0]  busy_cnt;
   logic              busy;
   logic              cmd_ok, wr_ok, rd_ok;
   logic [COL_W-1:0]  col;
   logic              at_end;
   logic              rmw;
   logic [PAGE_W-1:0] page;
   logic              disp_on;
   logic [LINE_W-1:0] start_line;
   logic              seg_rev, static_drv, duty32;
   logic [BYTE_W-1:0] latch;
   logic [BYTE_W-1:0] status;

   assign busy   = (busy_cnt != '0);
   assign cmd_ok = cmd_wr_i & ~busy;
   assign wr_ok  = dat_wr_i & ~busy;
   assign rd_ok  = dat_rd_i & ~busy;

   lcdc_cmd_decode #(
      .NUM_COLS  (NUM_COLS),
      .NUM_PAGES (NUM_PAGES)
   ) i_decode (
      .code_i (din_i),
      .op_o   (op)
   );

   lcdc_col_ctr #(
      .NUM_COLS (NUM_COLS),
      .COL_W    (COL_W)
   ) i_col (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (cmd_ok && op == OP_COL),
      .load_val_i   (din_i[COL_W-1:0]),
      .step_i       (wr_ok | rd_ok),
      .step_is_rd_i (rd_ok),
      .rmw_enter_i  (cmd_ok && op == OP_RMW),
      .rmw_leave_i  (cmd_ok && op == OP_END),
      .col_o        (col),
      .rmw_o        (rmw),
      .at_end_o     (at_end)
   );

   lcdc_rd_pipe #(
      .DATA_W        (BYTE_W),
      .HOLD_PAST_END (1'b0)
   ) i_rd_pipe (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_i       (rd_ok),
      .in_range_i (~at_end),
      .ram_data_i (ram_rdata_i),
      .latch_o    (latch)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cnt <= CNT_LOAD;
      end else if (cmd_ok && op == OP_SRST) begin
         busy_cnt <= CNT_LOAD;
      end else if (busy) begin
         busy_cnt <= busy_cnt - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_on    <= 1'b0;
         start_line <= '0;
         page       <= PAGE_TOP;
         seg_rev    <= 1'b0;
         static_drv <= 1'b0;
         duty32     <= 1'b1;
      end else if (cmd_ok) begin
         case (op)
            OP_DISP:   disp_on    <= din_i[0];
            OP_START:  start_line <= din_i[LINE_W-1:0];
            OP_PAGE:   page       <= din_i[PAGE_W-1:0];
            OP_ADC:    seg_rev    <= din_i[0];
            OP_STATIC: static_drv <= din_i[0];
            OP_DUTY:   duty32     <= din_i[0];
            OP_SRST: begin
               start_line <= '0;
               page       <= PAGE_TOP;
            end
            default: ;
         endcase
      end
   end

   assign status      = {busy, ~seg_rev, ~disp_on, busy, 4'b0000};
   assign host_dout_o = sts_rd_i ? status : latch;

   assign ram_addr_o   = {page, col};
   assign ram_we_o     = wr_ok & ~at_end;
   assign ram_re_o     = rd_ok & ~at_end;
   assign ram_wdata_o  = din_i;
   assign disp_on_o    = disp_on;
   assign start_line_o = start_line;
   assign seg_rev_o    = seg_rev;
   assign static_o     = static_drv;
   assign duty32_o     = duty32;
   assign rmw_o        = rmw;

endmodule

// File: rtl/lcdc_cmd_core_chk.sv
module lcdc_cmd_core_chk #(
   parameter int NUM_COLS = 80,
   parameter int COL_W    = 7,
   parameter int PAGE_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_wr_i,
   input logic              dat_wr_i,
   input logic              dat_rd_i,
   input logic              sts_rd_i,
   input logic              busy,
   input logic [COL_W-1:0]  col,
   input logic [PAGE_W-1:0] page,
   input logic              rmw,
   input logic              disp_on,
   input logic              ram_we_o,
   input logic [7:0]        host_dout_o
);

   localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS);

   assert_col_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      col <= COL_LAST);

   assert_no_write_past_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we_o |-> (col < COL_LAST));

   assert_write_steps_col_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr_i && !busy && !cmd_wr_i && !dat_rd_i && col < COL_LAST)
      |=> (col == $past(col) + COL_W'(1)));

   assert_page_only_by_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_wr_i |=> $stable(page));

   assert_busy_blocks_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_wr_i) |=> ($stable(disp_on) && $stable(page)));

   assert_rmw_read_holds_col_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rmw && dat_rd_i && !busy && !cmd_wr_i && !dat_wr_i) |=> $stable(col));

   assert_status_low_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sts_rd_i |-> (host_dout_o[3:0] == 4'b0000));

endmodule

bind lcdc_cmd_core lcdc_cmd_core_chk #(
   .NUM_COLS (NUM_COLS),
   .COL_W    (COL_W),
   .PAGE_W   (PAGE_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_wr_i    (cmd_wr_i),
   .dat_wr_i    (dat_wr_i),
   .dat_rd_i    (dat_rd_i),
   .sts_rd_i    (sts_rd_i),
   .busy        (busy),
   .col         (col),
   .page        (page),
   .rmw         (rmw),
   .disp_on     (disp_on),
   .ram_we_o    (ram_we_o),
   .host_dout_o (host_dout_o)
);

// File: tb/test_lcdc_cmd_core.sv
module test_lcdc_cmd_core;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wr_i = 1'b0, dat_wr_i = 1'b0, dat_rd_i = 1'b0, sts_rd_i = 1'b0;
   logic [7:0] din_i = 8'h00;
   logic [7:0] ram_rdata_i;
   logic [8:0] ram_addr_o;
   logic       ram_we_o, ram_re_o;
   logic [7:0] ram_wdata_o, host_dout_o;
   logic       disp_on_o, seg_rev_o, static_o, duty32_o, rmw_o;
   logic [4:0] start_line_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] mem [0:511];

   always #(CLK_PERIOD/2) clk = ~clk;

   lcdc_cmd_core i_lcdc_cmd_core (
      .clk, .rst_n, .cmd_wr_i, .dat_wr_i, .dat_rd_i, .sts_rd_i, .din_i,
      .ram_rdata_i, .ram_addr_o, .ram_we_o, .ram_re_o, .ram_wdata_o,
      .host_dout_o, .disp_on_o, .start_line_o, .seg_rev_o, .static_o,
      .duty32_o, .rmw_o
   );

   initial for (int i = 0; i < 512; i++) mem[i] = 8'h00;
   always @(posedge clk) if (ram_we_o) mem[ram_addr_o] <= ram_wdata_o;
   assign ram_rdata_i = mem[ram_addr_o];

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cmd(input logic [7:0] b);
      @(negedge clk); cmd_wr_i = 1'b1; din_i = b;
      @(negedge clk); cmd_wr_i = 1'b0;
   endtask

   task automatic wr(input logic [7:0] b);
      @(negedge clk); dat_wr_i = 1'b1; din_i = b;
      @(negedge clk); dat_wr_i = 1'b0;
   endtask

   task automatic rd(output logic [7:0] v);
      @(negedge clk); dat_rd_i = 1'b1; #1 v = host_dout_o;
      @(negedge clk); dat_rd_i = 1'b0;
   endtask

   task automatic sts(output logic [7:0] v);
      @(negedge clk); sts_rd_i = 1'b1; #1 v = host_dout_o;
      @(negedge clk); sts_rd_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [15:0] modes();
      return {disp_on_o, start_line_o, seg_rev_o, static_o, duty32_o, rmw_o, 6'b0};
   endfunction

   task automatic t_reset_state;
      logic [7:0] v;
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      sts(v);
      chk("R12 busy status after reset", v, 8'hF0);
      idle(6);
      chk("R1 display off", disp_on_o, 0);
      chk("R1 start line", start_line_o, 0);
      chk("R1 page and column", ram_addr_o, {2'd3, 7'd0});
      chk("R1 static/duty/seg/rmw", {static_o, duty32_o, seg_rev_o, rmw_o}, 4'b0100);
      sts(v);
      chk("R10 idle status", v, 8'h60);
      rd(v);
      chk("R1 latch cleared", v, 8'h00);
      cmd(8'h00);
   endtask

   task automatic t_display;
      logic [7:0] v;
      cmd(8'hAF);
      chk("R2 on", disp_on_o, 1);
      sts(v);
      chk("R10 status display on", v, 8'h40);
      cmd(8'hAE);
      chk("R2 off", disp_on_o, 0);
   endtask

   task automatic t_start_line;
      cmd(8'hD5);
      chk("R3 line 21", start_line_o, 21);
      cmd(8'hDF);
      chk("R3 line 31", start_line_o, 31);
      cmd(8'hC0);
      chk("R3 line 0", start_line_o, 0);
   endtask

   task automatic t_page_col;
      cmd(8'hB9);
      chk("R4 page 1", ram_addr_o[8:7], 1);
      cmd(8'h05);
      chk("R5 column 5", ram_addr_o[6:0], 5);
      cmd(8'h50);
      chk("R5 0x50 ignored", ram_addr_o, {2'd1, 7'd5});
      cmd(8'h7F);
      chk("R5 0x7F ignored", ram_addr_o, {2'd1, 7'd5});
      cmd(8'h4F);
      chk("R5 column 79", ram_addr_o[6:0], 79);
   endtask

   task automatic t_write_read;
      logic [7:0] v;
      cmd(8'hB9); cmd(8'h0A);
      @(negedge clk); dat_wr_i = 1'b1; din_i = 8'h11; #1;
      chk("R7 write strobe and address", {ram_we_o, ram_addr_o}, {1'b1, 2'd1, 7'd10});
      @(negedge clk); dat_wr_i = 1'b0;
      wr(8'h22); wr(8'h33); wr(8'h44);
      chk("R7 column stepped", ram_addr_o, {2'd1, 7'd14});
      chk("R4 page kept after writes", ram_addr_o[8:7], 1);
      cmd(8'h0A);
      rd(v);
      chk("R8 dummy read stale", v, 8'h00);
      rd(v); chk("R8 read 0x11", v, 8'h11);
      rd(v); chk("R8 read 0x22", v, 8'h22);
      rd(v); chk("R8 read 0x33", v, 8'h33);
      chk("R8 read steps column", ram_addr_o[6:0], 14);
      cmd(8'h0A);
      rd(v); chk("R8 stale after address change", v, 8'h44);
      rd(v); chk("R8 fresh after dummy", v, 8'h11);
   endtask

   task automatic t_saturate;
      logic [7:0] v;
      cmd(8'hB9); cmd(8'h4F);
      wr(8'hAA);
      chk("R7 column reaches 80", ram_addr_o[6:0], 80);
      @(negedge clk); dat_wr_i = 1'b1; din_i = 8'hBB; #1;
      chk("R7 no RAM write at 80", ram_we_o, 0);
      @(negedge clk); dat_wr_i = 1'b0;
      chk("R7 column saturates", ram_addr_o[6:0], 80);
      cmd(8'h4F);
      rd(v);
      rd(v); chk("R8 read last column", v, 8'hAA);
      @(negedge clk); dat_rd_i = 1'b1; #1;
      chk("R7 no RAM read at 80", ram_re_o, 0);
      @(negedge clk); dat_rd_i = 1'b0;
      rd(v); chk("R8 past end loads zero", v, 8'h00);
      chk("R7 column held after reads", ram_addr_o[6:0], 80);
   endtask

   task automatic t_modes;
      logic [7:0] v;
      cmd(8'hA1); chk("R6 reversed segments", seg_rev_o, 1);
      sts(v); chk("R10 status ADC bit low", v, 8'h20);
      cmd(8'hA0); chk("R6 normal segments", seg_rev_o, 0);
      cmd(8'hA5); chk("R6 static on", static_o, 1);
      cmd(8'hA4); chk("R6 static off", static_o, 0);
      cmd(8'hA8); chk("R6 1/16 duty", duty32_o, 0);
      cmd(8'hA9); chk("R6 1/32 duty", duty32_o, 1);
   endtask

   task automatic t_rmw;
      logic [7:0] v;
      cmd(8'hBA); cmd(8'h14);
      wr(8'h5A); wr(8'h5B);
      cmd(8'h14);
      cmd(8'hE0);
      chk("R9 mode entered", rmw_o, 1);
      rd(v);
      chk("R9 read holds column", ram_addr_o[6:0], 20);
      rd(v); chk("R9 read data", v, 8'h5A);
      wr(8'hA5);
      chk("R9 write steps column", ram_addr_o[6:0], 21);
      cmd(8'h30);
      chk("R9 column set ignored", ram_addr_o[6:0], 21);
      cmd(8'hEE);
      chk("R9 column restored", {rmw_o, ram_addr_o}, {1'b0, 2'd2, 7'd20});
      cmd(8'hEE);
      chk("R9 end outside mode no effect", {rmw_o, ram_addr_o}, {1'b0, 2'd2, 7'd20});
      rd(v);
      rd(v); chk("R9 modified byte", v, 8'hA5);
   endtask

   task automatic t_soft_reset;
      logic [7:0] v;
      cmd(8'hD3); cmd(8'hB8); cmd(8'hAF); cmd(8'h07);
      cmd(8'hE2);
      sts(v);
      chk("R10 busy during soft reset", v, 8'hD0);
      wr(8'h99);
      chk("R12 write ignored while busy", ram_addr_o[6:0], 7);
      idle(5);
      cmd(8'hAE);
      chk("R12 command accepted after window", disp_on_o, 0);
      cmd(8'hAF);
      chk("R11 start line cleared", start_line_o, 0);
      chk("R11 page 3 column kept", ram_addr_o, {2'd3, 7'd7});
      cmd(8'hE2);
      cmd(8'hAE);
      chk("R12 command ignored while busy", disp_on_o, 1);
      chk("R11 display kept", disp_on_o, 1);
      idle(5);
      sts(v);
      chk("R10 ready after window", v, 8'h40);
   endtask

   task automatic t_undefined;
      logic [15:0] m;
      logic [8:0]  a;
      m = modes();
      a = ram_addr_o;
      cmd(8'hA2); cmd(8'hB4); cmd(8'hFF); cmd(8'hE1); cmd(8'hBC); cmd(8'hAC);
      chk("R13 modes unchanged", modes(), m);
      chk("R13 address unchanged", ram_addr_o, a);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_display();
      t_start_line();
      t_page_col();
      t_write_read();
      t_saturate();
      t_modes();
      t_rmw();
      t_soft_reset();
      t_undefined();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule